// File: doc/BRIEF.md
# Strap-Controlled Core Reset Holder

This block sits between the system reset and an embedded processor core. While the system reset is low it watches a bus of configuration strap lines. When reset lifts, it keeps the last value it saw. Two of those lines decide the start-up mode:

- **Auto mode.** The core leaves reset on its own after a short fixed delay.
- **Hold mode.** The core is kept in reset until the host writes a release bit. This lets the host load code and set up the platform before the core runs.

The same strap decision sets up a bank of PCI-style base-address registers.

- **Hold mode.** Only the first window is enabled. It is a 16 MB window whose default base is 0xFF00_0000, the configuration register space. Every other window is disabled.
- **Auto mode.** Every window is enabled with a 1 MB size.

A host-writable hide bit tells the enumeration logic whether the translation unit should be seen at all.

The reset sequencer is a four-state machine:

- **ST_POR** while reset is low.
- **ST_COUNT** for the auto-release delay.
- **ST_WAIT_HOST** while the core is held for the host.
- **ST_RUN** once the core is out of reset.

Its transitions are:

- **T_AUTO**: ST_POR to ST_COUNT.
- **T_HOLD**: ST_POR to ST_WAIT_HOST.
- **T_DONE**: ST_COUNT to ST_RUN.
- **T_RELEASE**: ST_WAIT_HOST to ST_RUN.
- **T_RESET**: any state to ST_POR whenever `rst_n` is low at a clock edge.

Register map, by word address on `reg_addr`:

| Address | Register | Contents |
|---|---|---|
| 0 | Control/status | bit0 hold mode, bit1 core running / release, bits [15:8] latched strap lines |
| 1 | Visibility | bit0 hide |
| 4 + i | Window i | base address |

Top module: `core_hold_ctrl`

## Requirements
- R1: The strap lines are sampled on every clock edge while `rst_n` is low, and the value from the last such edge is kept. The hold strap is line 5 and the retry strap is line 6. The kept value appears at status bits [15:8]. Changing `strap_bus` after reset has no effect on the mode or on those bits.
- R2: Auto mode is selected when the hold strap is 0, or when the retry strap is 1. In auto mode `core_rst_n` rises after the 4th rising edge with `rst_n` high, and stays high.
- R3: Hold mode is selected when the hold strap is 1 and the retry strap is 0. In hold mode `core_rst_n` stays low after reset for as long as no release is written.
- R4: In hold mode, a write to address 0 with bit1 = 1 raises `core_rst_n` after that clock edge. A write with bit1 = 0 leaves the core held.
- R5: A read of address 0 returns:
  - bit1 = 1 exactly when the core is out of reset;
  - bit0 = 1 in hold mode.
  Writing the release bit while the core is running changes neither `core_rst_n` nor the read value.
- R6: In hold mode:
  - `bar_en` has only bit 0 set, and window 0 has mask 0xFF00_0000 and reads 0xFF00_0000 after reset;
  - the other windows have mask 0, read 0, and ignore writes.
- R7: A write to an enabled window stores the written value ANDed with its mask. In hold mode, writing 0xFFFF_FFFF to window 0 reads back 0xFF00_0000.
- R8: In auto mode every window is enabled, with mask 0xFFF0_0000 and a base of 0 after reset.
- R9: The hide bit (address 1, bit0) is 0 after reset, so `unit_visible` = 1. Writing it sets `unit_visible` to its inverse after the edge, and the bit reads back.
- R10: `rst_n` low at a clock edge forces `core_rst_n` low after that edge. This holds even when a release write arrives at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, synchronous |
| strap_bus | input | 8 | Configuration strap lines, sampled during reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| core_rst_n | output | 1 | Core reset, active low |
| bar_en | output | 3 | Per-window enable |
| bar_mask | output | 96 | Per-window size masks, window i at bits [32i+31:32i] |
| unit_visible | output | 1 | High when the unit may be enumerated (hide bit clear) |

## Verification
The host release and the system reset both act on the core reset sequencer, so they can land at the same clock edge. The bench provokes this by driving `rst_n` low while it presents a release write to address 0, with the core held in hold mode. It judges the outcome in three ways:
- `core_rst_n` must be low after that edge;
- after reset lifts again with the hold strap still set, the core must stay held;
- the status read must show bit1 clear.

// File: rtl/core_hold_pkg.sv
package core_hold_pkg;

    typedef enum logic [1:0] {
        ST_POR       = 2'd0,
        ST_COUNT     = 2'd1,
        ST_WAIT_HOST = 2'd2,
        ST_RUN       = 2'd3
    } rst_state_e;

    localparam int REG_ADDR_W = 4;
    localparam int REG_DATA_W = 32;

    localparam logic [REG_ADDR_W-1:0] ADDR_STATUS   = 4'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_VISCTL   = 4'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_WIN_BASE = 4'd4;

    localparam int STAT_HOLD_BIT  = 0;
    localparam int STAT_RUN_BIT   = 1;
    localparam int STAT_STRAP_LSB = 8;

    typedef struct packed {
        logic hold_strap;
        logic retry_strap;
    } strap_pair_t;

endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import core_hold_pkg::*;
#(
    parameter int STRAP_W   = 8,
    parameter int HOLD_BIT  = 5,
    parameter int RETRY_BIT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_bus,
    output logic [STRAP_W-1:0] strap_q,
    output logic               hold_mode,
    output logic               hold_live
);

    strap_pair_t live_pair;
    strap_pair_t kept_pair;

    // Capture every cycle while reset is low; freeze afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap_bus;
        end
    end

    always_comb begin
        live_pair.hold_strap  = strap_bus[HOLD_BIT];
        live_pair.retry_strap = strap_bus[RETRY_BIT];
        kept_pair.hold_strap  = strap_q[HOLD_BIT];
        kept_pair.retry_strap = strap_q[RETRY_BIT];
    end

    // Hold mode is only honoured when retry is strapped low.
    assign hold_live = live_pair.hold_strap & ~live_pair.retry_strap;
    assign hold_mode = kept_pair.hold_strap & ~kept_pair.retry_strap;

    // R1
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n)) |-> $stable(strap_q));

endmodule

// File: rtl/core_rst_fsm.sv
module core_rst_fsm
    import core_hold_pkg::*;
#(
    parameter int RELEASE_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_mode,
    input  logic release_req,
    output logic core_rst_n,
    output logic core_run
);

    localparam int CNT_W = (RELEASE_DLY > 2) ? $clog2(RELEASE_DLY) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RELEASE_DLY - 2);

    rst_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_POR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_POR: begin
                cnt_d = '0;
                if (hold_mode) state_d = ST_WAIT_HOST;   // T_HOLD
                else           state_d = ST_COUNT;       // T_AUTO
            end
            ST_COUNT: begin
                if (cnt_q == CNT_LAST) state_d = ST_RUN; // T_DONE
                else                   cnt_d = cnt_q + 1'b1;
            end
            ST_WAIT_HOST: begin
                if (release_req) state_d = ST_RUN;       // T_RELEASE
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_POR;
        endcase
    end

    // Outputs
    always_comb begin
        core_run = 1'b0;
        unique case (state_q)
            ST_POR, ST_COUNT, ST_WAIT_HOST: core_run = 1'b0;
            ST_RUN:                         core_run = 1'b1;
            default:                        core_run = 1'b0;
        endcase
        core_rst_n = core_run;
    end

    // R5
    core_stays_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_run |=> core_run);

    // R3
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_run) |-> (!hold_mode || $past(release_req)));

    // R2
    auto_never_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_mode |-> (state_q != ST_WAIT_HOST));

endmodule

// File: rtl/bar_bank.sv
module bar_bank
    import core_hold_pkg::*;
#(
    parameter int               NUM_BAR   = 3,
    parameter int               HELD_LOG2 = 24,
    parameter int               AUTO_LOG2 = 20,
    parameter logic [31:0]      HELD_BASE = 32'hFF00_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold_live,
    input  logic                    hold_mode,
    input  logic                    wr_en,
    input  logic [$clog2(NUM_BAR)-1:0] wr_idx,
    input  logic [31:0]             wr_data,
    input  logic [$clog2(NUM_BAR)-1:0] rd_idx,
    output logic [31:0]             rd_data,
    output logic [NUM_BAR-1:0]      bar_en,
    output logic [NUM_BAR*32-1:0]   bar_mask
);

    localparam logic [31:0] HELD_MASK = ~((32'd1 << HELD_LOG2) - 32'd1);
    localparam logic [31:0] AUTO_MASK = ~((32'd1 << AUTO_LOG2) - 32'd1);

    logic [31:0] base_q [NUM_BAR];
    logic [31:0] mask_w [NUM_BAR];

    for (genvar i = 0; i < NUM_BAR; i++) begin : g_win
        localparam logic [31:0] HOLD_MASK_I = (i == 0) ? HELD_MASK : 32'd0;
        localparam logic [31:0] HOLD_BASE_I = (i == 0) ? HELD_BASE : 32'd0;

        assign mask_w[i] = hold_mode ? HOLD_MASK_I : AUTO_MASK;
        assign bar_en[i] = (mask_w[i] != 32'd0);
        assign bar_mask[i*32 +: 32] = mask_w[i];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= hold_live ? (HOLD_BASE_I & HELD_MASK) : 32'd0;
            end else if (wr_en && (wr_idx == i[$clog2(NUM_BAR)-1:0]) && bar_en[i]) begin
                base_q[i] <= wr_data & mask_w[i];
            end
        end

        // R7
        base_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (base_q[i] & ~mask_w[i]) == 32'd0);

        if (i > 0) begin : g_off
            // R6
            held_win_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hold_mode |-> (!bar_en[i] && base_q[i] == 32'd0));
        end
    end

    always_comb begin
        rd_data = 32'd0;
        for (int k = 0; k < NUM_BAR; k++) begin
            if (rd_idx == k[$clog2(NUM_BAR)-1:0]) rd_data = base_q[k];
        end
    end

endmodule

// File: rtl/reg_decode.sv
module reg_decode
    import core_hold_pkg::*;
#(
    parameter int STRAP_W = 8,
    parameter int NUM_BAR = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [REG_ADDR_W-1:0]   reg_addr,
    input  logic [1:0]              ctl_bits,
    input  logic                    core_run,
    input  logic                    hold_mode,
    input  logic [STRAP_W-1:0]      strap_q,
    input  logic [31:0]             win_rdata,
    output logic                    release_req,
    output logic                    win_we,
    output logic [$clog2(NUM_BAR)-1:0] win_idx,
    output logic                    unit_visible,
    output logic [REG_DATA_W-1:0]   reg_rdata
);

    localparam int IDX_W = $clog2(NUM_BAR);

    logic                  hide_q;
    logic [REG_ADDR_W-1:0] win_off;
    logic                  in_win;

    assign win_off = reg_addr - ADDR_WIN_BASE;
    assign in_win  = (reg_addr >= ADDR_WIN_BASE) &&
                     (win_off < REG_ADDR_W'(NUM_BAR));
    assign win_idx = win_off[IDX_W-1:0];
    assign win_we  = reg_we && in_win;

    assign release_req = reg_we && (reg_addr == ADDR_STATUS) && ctl_bits[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hide_q <= 1'b0;
        end else if (reg_we && reg_addr == ADDR_VISCTL) begin
            hide_q <= ctl_bits[0];
        end
    end

    assign unit_visible = ~hide_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_STATUS) begin
            reg_rdata[STAT_HOLD_BIT] = hold_mode;
            reg_rdata[STAT_RUN_BIT]  = core_run;
            reg_rdata[STAT_STRAP_LSB +: STRAP_W] = strap_q;
        end else if (reg_addr == ADDR_VISCTL) begin
            reg_rdata[0] = hide_q;
        end else if (in_win) begin
            reg_rdata = win_rdata;
        end
    end

    // R9
    hide_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_VISCTL) |=> (unit_visible == !$past(ctl_bits[0])));

endmodule

// File: rtl/core_hold_ctrl.sv
module core_hold_ctrl
    import core_hold_pkg::*;
#(
    parameter int STRAP_W     = 8,
    parameter int HOLD_BIT    = 5,
    parameter int RETRY_BIT   = 6,
    parameter int RELEASE_DLY = 4,
    parameter int NUM_BAR     = 3,
    parameter int HELD_LOG2   = 24,
    parameter int AUTO_LOG2   = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [STRAP_W-1:0]    strap_bus,
    input  logic                  reg_we,
    input  logic [3:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  core_rst_n,
    output logic [NUM_BAR-1:0]    bar_en,
    output logic [NUM_BAR*32-1:0] bar_mask,
    output logic                  unit_visible
);

    localparam int IDX_W = $clog2(NUM_BAR);

    logic [STRAP_W-1:0] strap_q;
    logic               hold_mode;
    logic               hold_live;
    logic               release_req;
    logic               core_run;
    logic               win_we;
    logic [IDX_W-1:0]   win_idx;
    logic [31:0]        win_rdata;

    strap_latch #(
        .STRAP_W  (STRAP_W),
        .HOLD_BIT (HOLD_BIT),
        .RETRY_BIT(RETRY_BIT)
    ) u_straps (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_bus(strap_bus),
        .strap_q  (strap_q),
        .hold_mode(hold_mode),
        .hold_live(hold_live)
    );

    core_rst_fsm #(
        .RELEASE_DLY(RELEASE_DLY)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_mode  (hold_mode),
        .release_req(release_req),
        .core_rst_n (core_rst_n),
        .core_run   (core_run)
    );

    bar_bank #(
        .NUM_BAR  (NUM_BAR),
        .HELD_LOG2(HELD_LOG2),
        .AUTO_LOG2(AUTO_LOG2)
    ) u_wins (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_live(hold_live),
        .hold_mode(hold_mode),
        .wr_en    (win_we),
        .wr_idx   (win_idx),
        .wr_data  (reg_wdata),
        .rd_idx   (win_idx),
        .rd_data  (win_rdata),
        .bar_en   (bar_en),
        .bar_mask (bar_mask)
    );

    reg_decode #(
        .STRAP_W(STRAP_W),
        .NUM_BAR(NUM_BAR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .ctl_bits    (reg_wdata[1:0]),
        .core_run    (core_run),
        .hold_mode   (hold_mode),
        .strap_q     (strap_q),
        .win_rdata   (win_rdata),
        .release_req (release_req),
        .win_we      (win_we),
        .win_idx     (win_idx),
        .unit_visible(unit_visible),
        .reg_rdata   (reg_rdata)
    );

endmodule

// File: tb/core_hold_ctrl_tb_top.sv
module core_hold_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  strap_bus = 8'h00;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        core_rst_n;
    logic [2:0]  bar_en;
    logic [95:0] bar_mask;
    logic        unit_visible;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    core_hold_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .strap_bus(strap_bus),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_rst_n(core_rst_n), .bar_en(bar_en),
        .bar_mask(bar_mask), .unit_visible(unit_visible)
    );

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reset_with(input logic [7:0] s);
        @(negedge clk);
        rst_n = 1'b0; strap_bus = s; reg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, {64'd0, reg_rdata}, {64'd0, exp});
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0; strap_bus = 8'h20;
        repeat (2) @(negedge clk);
        check("R10 core held in reset", {95'd0, core_rst_n}, 96'd0);
        check("R9 visible at reset", {95'd0, unit_visible}, 96'd1);
    endtask

    task automatic t_auto();
        reset_with(8'h00);
        repeat (3) @(negedge clk);
        check("R2 still in reset after 3 edges", {95'd0, core_rst_n}, 96'd0);
        @(negedge clk);
        check("R2 released after 4th edge", {95'd0, core_rst_n}, 96'd1);
        rd_check("R5 status auto", 4'd0, 32'h0000_0002);
        check("R8 all windows enabled", {93'd0, bar_en}, 96'd7);
        check("R8 window masks", bar_mask, {3{32'hFFF0_0000}});
        rd_check("R8 base zero", 4'd5, 32'd0);
        wr(4'd5, 32'h1234_5678);
        rd_check("R7 auto masked write", 4'd5, 32'h1230_0000);
        wr(4'd0, 32'h0000_0002);
        check("R5 release while running", {95'd0, core_rst_n}, 96'd1);
        rd_check("R5 status unchanged", 4'd0, 32'h0000_0002);
        strap_bus = 8'h60;
        repeat (3) @(negedge clk);
        rd_check("R1 strap change ignored", 4'd0, 32'h0000_0002);
    endtask

    task automatic t_hold();
        // strap changes inside reset: last value wins
        @(negedge clk);
        rst_n = 1'b0; strap_bus = 8'h00;
        repeat (2) @(negedge clk);
        strap_bus = 8'h20;
        @(negedge clk);
        rst_n = 1'b1;
        strap_bus = 8'hFF;
        repeat (20) @(negedge clk);
        check("R3 core held", {95'd0, core_rst_n}, 96'd0);
        rd_check("R1 latched hold strap", 4'd0, 32'h0000_2001);
        check("R6 only window 0", {93'd0, bar_en}, 96'd1);
        check("R6 masks", bar_mask, {64'd0, 32'hFF00_0000});
        rd_check("R6 window0 default", 4'd4, 32'hFF00_0000);
        wr(4'd6, 32'hFFFF_FFFF);
        rd_check("R6 disabled window ignores write", 4'd6, 32'd0);
        wr(4'd4, 32'd0);
        rd_check("R7 window0 cleared", 4'd4, 32'd0);
        wr(4'd4, 32'hFFFF_FFFF);
        rd_check("R7 size probe", 4'd4, 32'hFF00_0000);
        wr(4'd0, 32'h0000_0001);
        check("R4 bit1 clear keeps hold", {95'd0, core_rst_n}, 96'd0);
        wr(4'd0, 32'h0000_0002);
        check("R4 release", {95'd0, core_rst_n}, 96'd1);
        rd_check("R5 status after release", 4'd0, 32'h0000_2003);
    endtask

    task automatic t_retry_blocks_hold();
        reset_with(8'h60);
        repeat (3) @(negedge clk);
        check("R2 retry high: not yet", {95'd0, core_rst_n}, 96'd0);
        @(negedge clk);
        check("R2 retry high: auto release", {95'd0, core_rst_n}, 96'd1);
        rd_check("R2 status retry", 4'd0, 32'h0000_6002);
    endtask

    task automatic t_hide();
        rd_check("R9 hide reset value", 4'd1, 32'd0);
        wr(4'd1, 32'd1);
        check("R9 hidden", {95'd0, unit_visible}, 96'd0);
        rd_check("R9 hide readback", 4'd1, 32'd1);
        wr(4'd1, 32'd0);
        check("R9 visible again", {95'd0, unit_visible}, 96'd1);
    endtask

    task automatic t_reset_vs_release();
        reset_with(8'h20);
        repeat (6) @(negedge clk);
        check("R3 held before collision", {95'd0, core_rst_n}, 96'd0);
        reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h2; rst_n = 1'b0;
        @(negedge clk);
        reg_we = 1'b0;
        check("R10 reset beats release", {95'd0, core_rst_n}, 96'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R10 still held after reset", {95'd0, core_rst_n}, 96'd0);
        rd_check("R10 status not released", 4'd0, 32'h0000_2001);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_auto();
        t_hold();
        t_retry_blocks_hold();
        t_hide();
        t_reset_vs_release();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule